// File: doc/BRIEF.md
# Quadrature DDS Transmit Modulator

This block produces a quadrature transmit carrier and drives it to a pair of parallel DAC ports. A phase accumulator advances by a tuning word on every clock. The top bits of the accumulator select entries from a sine lookup that holds one quarter of a wave. The block reads a cosine sample and a sine sample at the same phase, scales each by an audio sample taken from the received I2S words, and converts each signed result to offset binary for the DACs.

The transmit key is carried in the least significant bits of the received left and right words. When the key is off, both DACs sit at mid-scale. A configuration input selects the audio that goes back out on the I2S transmit words: either the received words themselves, or the microphone sample on the left channel with the right channel silent. The transmit path runs on the same clock as the receive side. The I2S serialiser, the codec clocking and any register access are outside this block.

Top module: `tx_quad_mod`

## Requirements
- R1: `dacA` carries the cosine product and `dacB` carries the sine product. At table index 0 the cosine is +2047 and the sine is 0, and at index 256 the cosine is 0 and the sine is +2047 (12-bit table, 1024-entry wave).
- R2: Each DAC code is the low 12 bits of the signed product, with bit 11 inverted. For example, a product of -2047 gives 0x001 and a product of +2047 gives 0xFFF.
- R3: The product is (carrier × amplitude) arithmetically shifted right by 15, rounding toward minus infinity. The amplitude is the latched left word with bit 0 forced to 0. With an amplitude of 0x4000, a carrier of +2047 gives 0xBFF and a carrier of -2047 gives 0x400.
- R4: The key is bit 0 of the latched left word OR bit 0 of the latched right word. While the key is 0, both DACs output 0x800.
- R5: A 32-bit accumulator adds `tuneWord` on every clock and its top 10 bits index the table. The sample on the DACs after a clock edge uses the index from two edges earlier. With a tuning word of 2^22, the output repeats every 1024 cycles, and `dacA` at step j equals `dacB` at step j+256.
- R6: The wave is odd about half a turn. With an amplitude of -32768, the `dacB` codes at steps j and j+512 always add up to 4096.
- R7: `rxLeft`, `rxRight` and `micSample` are captured on the edge where `rxStrobe` is 1. The captured values are held until the next strobe. Changes to these inputs without a strobe do not affect any output.
- R8: With `loopEn` = 1, `txLeft`/`txRight` return the captured received words. With `loopEn` = 0, `txLeft` returns the captured microphone sample and `txRight` is 0.
- R9: While `rst` is 1, both DACs hold 0x800 and the captured words are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, shared with the receive path |
| rst | input | 1 | Synchronous reset, active high |
| tuneWord | input | 32 | Phase increment added on every clock |
| rxStrobe | input | 1 | One-cycle strobe that captures the audio inputs |
| rxLeft | input | 16 | Received left word; bit 0 is a key bit |
| rxRight | input | 16 | Received right word; bit 0 is a key bit |
| micSample | input | 16 | Microphone audio sample |
| loopEn | input | 1 | 1: loop received audio back; 0: return microphone audio |
| dacA | output | 12 | Cosine DAC code, offset binary |
| dacB | output | 12 | Sine DAC code, offset binary |
| txLeft | output | 16 | Left word returned over I2S |
| txRight | output | 16 | Right word returned over I2S |

## Verification
The bench builds the block with its default widths: a 32-bit accumulator, a 10-bit index, a 12-bit table, 16-bit audio and a 12-bit DAC. With these values a tuning word of 2^30 or 2^31 lands exactly on the quarter-turn table points, so the DAC codes can be predicted exactly. A tuning word of 2^22 steps through every one of the 1024 indices, so the bench can check the quarter-turn offset between `dacA` and `dacB`, the half-turn antisymmetry and the period over a full cycle. An amplitude of -32768 makes the scaled product equal to the negated carrier, and an amplitude of 0x4000 exposes the floor rounding of the shift.

// File: rtl/txqm_pkg.sv
package txqm_pkg;

  // Strobes and flags passed from control to datapath
  typedef struct packed {
    logic keyOn;
  } ctrlBus_t;

  // Quarter-wave sine entry k (0..N/4) for a 2^idxW-entry wave, integer rational approximation
  function automatic longint quarterSample(input int k, input int idxW, input int tblW);
    longint half;
    longint amax;
    longint kk;
    longint p;
    longint num;
    longint den;
    half = longint'(1) << (idxW - 1);
    amax = (longint'(1) << (tblW - 1)) - 1;
    kk   = longint'(k);
    p    = kk * (half - kk);
    num  = amax * 16 * p;
    den  = 5 * half * half - 4 * p;
    return (num + den / 2) / den;
  endfunction

endpackage

// File: rtl/txqm_ctrl.sv
module txqm_ctrl #(
  parameter int AUD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rxStrobe,
  input  logic [AUD_W-1:0]        rxLeft,
  input  logic [AUD_W-1:0]        rxRight,
  input  logic [AUD_W-1:0]        micSample,
  input  logic                    loopEn,
  output txqm_pkg::ctrlBus_t      bus,
  output logic signed [AUD_W-1:0] amp,
  output logic [AUD_W-1:0]        txLeft,
  output logic [AUD_W-1:0]        txRight
);

  logic [AUD_W-1:0] leftQ;
  logic [AUD_W-1:0] rightQ;
  logic [AUD_W-1:0] micQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      leftQ  <= '0;
      rightQ <= '0;
      micQ   <= '0;
    end else if (rxStrobe) begin
      leftQ  <= rxLeft;
      rightQ <= rxRight;
      micQ   <= micSample;
    end
  end

  // key lives in the LSB of either word; the audio drops that bit
  always_comb begin
    bus.keyOn = leftQ[0] | rightQ[0];
    amp       = signed'({leftQ[AUD_W-1:1], 1'b0});
    txLeft    = loopEn ? leftQ  : micQ;
    txRight   = loopEn ? rightQ : '0;
  end

endmodule

// File: rtl/txqm_dpath.sv
module txqm_dpath #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int TBL_W   = 12,
  parameter int AUD_W   = 16,
  parameter int DAC_W   = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      tuneWord,
  input  logic signed [AUD_W-1:0] amp,
  input  txqm_pkg::ctrlBus_t      bus,
  output logic [DAC_W-1:0]        dacA,
  output logic [DAC_W-1:0]        dacB
);

  localparam int QB    = IDX_W - 2;
  localparam int QTR   = 1 << QB;
  localparam int PW    = TBL_W + AUD_W;
  localparam int SHIFT = PW - 1 - DAC_W;
  localparam logic [QB:0]      QTR_V = QTR[QB:0];
  localparam logic [DAC_W-1:0] MID   = {1'b1, {(DAC_W-1){1'b0}}};

  logic [PHASE_W-1:0] acc;
  logic [IDX_W-1:0]   accIdx;
  logic signed [TBL_W-1:0] quarterRom [QTR+1];
  logic signed [TBL_W-1:0] waveR [2];   // [0] sine, [1] cosine

  for (genvar k = 0; k <= QTR; k++) begin : g_rom
    assign quarterRom[k] = TBL_W'(txqm_pkg::quarterSample(k, IDX_W, TBL_W));
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + tuneWord;
  end

  assign accIdx = acc[PHASE_W-1 -: IDX_W];

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    logic [IDX_W-1:0] idx;
    logic [1:0]       quad;
    logic [QB:0]      fold;
    logic signed [TBL_W-1:0] mag;

    always_comb begin
      idx  = accIdx + ((ch == 1) ? IDX_W'(QTR) : IDX_W'(0));
      quad = idx[IDX_W-1 -: 2];
      fold = quad[0] ? (QTR_V - {1'b0, idx[QB-1:0]}) : {1'b0, idx[QB-1:0]};
      mag  = quarterRom[fold];
    end

    always_ff @(posedge clk) begin
      if (rst) waveR[ch] <= '0;
      else     waveR[ch] <= quad[1] ? -mag : mag;
    end
  end

  function automatic logic [DAC_W-1:0] toDac(input logic signed [TBL_W-1:0] carrier,
                                             input logic signed [AUD_W-1:0] a);
    logic signed [PW-1:0] prod;
    prod = PW'(carrier) * PW'(a);
    return prod[SHIFT +: DAC_W] ^ MID;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      dacA <= MID;
      dacB <= MID;
    end else if (bus.keyOn) begin
      dacA <= toDac(waveR[1], amp);
      dacB <= toDac(waveR[0], amp);
    end else begin
      dacA <= MID;
      dacB <= MID;
    end
  end

endmodule

// File: rtl/tx_quad_mod.sv
module tx_quad_mod #(
  parameter int PHASE_W = 32,
  parameter int IDX_W   = 10,
  parameter int TBL_W   = 12,
  parameter int AUD_W   = 16,
  parameter int DAC_W   = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] tuneWord,
  input  logic               rxStrobe,
  input  logic [AUD_W-1:0]   rxLeft,
  input  logic [AUD_W-1:0]   rxRight,
  input  logic [AUD_W-1:0]   micSample,
  input  logic               loopEn,
  output logic [DAC_W-1:0]   dacA,
  output logic [DAC_W-1:0]   dacB,
  output logic [AUD_W-1:0]   txLeft,
  output logic [AUD_W-1:0]   txRight
);

  txqm_pkg::ctrlBus_t      ctrlBus;
  logic signed [AUD_W-1:0] ampSig;

  txqm_ctrl #(.AUD_W(AUD_W)) ctrl_i (
    .clk(clk), .rst(rst), .rxStrobe(rxStrobe), .rxLeft(rxLeft), .rxRight(rxRight),
    .micSample(micSample), .loopEn(loopEn), .bus(ctrlBus), .amp(ampSig),
    .txLeft(txLeft), .txRight(txRight)
  );

  txqm_dpath #(
    .PHASE_W(PHASE_W), .IDX_W(IDX_W), .TBL_W(TBL_W), .AUD_W(AUD_W), .DAC_W(DAC_W)
  ) dpath_i (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .amp(ampSig), .bus(ctrlBus),
    .dacA(dacA), .dacB(dacB)
  );

endmodule

// File: rtl/tx_quad_mod_chk.sv
module tx_quad_mod_chk #(
  parameter int AUD_W = 16,
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             keyOn,
  input logic             rxStrobe,
  input logic             loopEn,
  input logic [DAC_W-1:0] dacA,
  input logic [DAC_W-1:0] dacB,
  input logic [AUD_W-1:0] txLeft,
  input logic [AUD_W-1:0] txRight
);

  localparam logic [DAC_W-1:0] MID = {1'b1, {(DAC_W-1){1'b0}}};

  // R4
  key_mute_chk: assert property (@(posedge clk) disable iff (rst)
    !keyOn |=> (dacA == MID && dacB == MID));

  // R9
  reset_mid_chk: assert property (@(posedge clk)
    rst |=> (dacA == MID && dacB == MID && txRight == '0));

  // R8
  mic_right_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !loopEn |-> txRight == '0);

  // R7
  hold_words_chk: assert property (@(posedge clk) disable iff (rst)
    !rxStrobe |=> ($stable(loopEn) -> ($stable(txLeft) && $stable(txRight))));

endmodule

bind tx_quad_mod tx_quad_mod_chk #(.AUD_W(AUD_W), .DAC_W(DAC_W)) chk_i (
  .clk(clk), .rst(rst), .keyOn(ctrlBus.keyOn), .rxStrobe(rxStrobe), .loopEn(loopEn),
  .dacA(dacA), .dacB(dacB), .txLeft(txLeft), .txRight(txRight)
);

// File: tb/tx_quad_mod_tb_top.sv
module tx_quad_mod_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] tuneWord = '0;
  logic        rxStrobe = 1'b0;
  logic [15:0] rxLeft = '0;
  logic [15:0] rxRight = '0;
  logic [15:0] micSample = '0;
  logic        loopEn = 1'b1;
  logic [11:0] dacA;
  logic [11:0] dacB;
  logic [15:0] txLeft;
  logic [15:0] txRight;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;
  int recA [1300];
  int recB [1300];

  always #10 clk = ~clk;

  tx_quad_mod dut_i (
    .clk(clk), .rst(rst), .tuneWord(tuneWord), .rxStrobe(rxStrobe), .rxLeft(rxLeft),
    .rxRight(rxRight), .micSample(micSample), .loopEn(loopEn), .dacA(dacA), .dacB(dacB),
    .txLeft(txLeft), .txRight(txRight)
  );

  task automatic check(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reset with a given tuning word, then capture one audio frame; returns at step 0
  task automatic startRun(input logic [31:0] tw, input logic [15:0] l, input logic [15:0] r,
                          input logic [15:0] m);
    @(negedge clk);
    rst = 1'b1; tuneWord = tw; rxStrobe = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0; rxStrobe = 1'b1; rxLeft = l; rxRight = r; micSample = m;
    @(negedge clk);
    rxStrobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1; loopEn = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 dacA in reset", dacA, 12'h800);
    check("R9 dacB in reset", dacB, 12'h800);
    check("R9 txLeft in reset", txLeft, 0);
    check("R9 txRight in reset", txRight, 0);
  endtask

  // quarter-turn steps, amplitude -32768, key from the right LSB
  task automatic testCardinal();
    int expA [4] = '{12'h001, 12'h800, 12'hFFF, 12'h800};
    int expB [4] = '{12'h800, 12'h001, 12'h800, 12'hFFF};
    startRun(32'h4000_0000, 16'h8000, 16'h0001, 16'h0);
    for (int j = 0; j < 8; j++) begin
      check($sformatf("R1 R2 cosine on dacA step %0d", j), dacA, expA[j % 4]);
      check($sformatf("R1 R2 sine on dacB step %0d", j), dacB, expB[j % 4]);
      @(negedge clk);
    end
  endtask

  // half-turn steps, amplitude 0x4000 with key from the left LSB
  task automatic testScale();
    startRun(32'h8000_0000, 16'h4001, 16'h0000, 16'h0);
    for (int j = 0; j < 4; j++) begin
      check($sformatf("R3 dacA step %0d", j), dacA, (j % 2 == 0) ? 12'hBFF : 12'h400);
      check($sformatf("R3 dacB step %0d", j), dacB, 12'h800);
      @(negedge clk);
    end
  endtask

  task automatic testKeyOff();
    startRun(32'h4000_0000, 16'h7FFE, 16'h8000, 16'h0);
    for (int j = 0; j < 6; j++) begin
      check("R4 dacA with key off", dacA, 12'h800);
      check("R4 dacB with key off", dacB, 12'h800);
      @(negedge clk);
    end
  endtask

  task automatic testHold();
    int expA [4] = '{12'h001, 12'h800, 12'hFFF, 12'h800};
    startRun(32'h4000_0000, 16'h8000, 16'h0001, 16'h0);
    rxLeft = 16'h4000; rxRight = 16'h0000; micSample = 16'h1111;
    for (int j = 0; j < 6; j++) begin
      check("R7 dacA held without strobe", dacA, expA[j % 4]);
      @(negedge clk);
    end
    check("R7 txLeft held without strobe", txLeft, 16'h8000);
    rxStrobe = 1'b1;
    @(negedge clk);
    rxStrobe = 1'b0;
    @(negedge clk);
    for (int j = 0; j < 4; j++) begin
      check("R7 R4 dacA after new unkeyed word", dacA, 12'h800);
      @(negedge clk);
    end
  endtask

  task automatic testSweep();
    int bad;
    startRun(32'h0040_0000, 16'h8000, 16'h0001, 16'h0);
    for (int j = 0; j < 1300; j++) begin
      recA[j] = int'(dacA);
      recB[j] = int'(dacB);
      @(negedge clk);
    end
    check("R5 sine peak at index 256", recB[256], 12'h001);
    bad = 0;
    for (int j = 0; j < 1024; j++) if (recA[j] != recB[j + 256]) bad++;
    check("R5 cosine leads sine by a quarter turn (mismatches)", bad, 0);
    bad = 0;
    for (int j = 0; j < 276; j++) if (recB[j] != recB[j + 1024]) bad++;
    check("R5 period of 1024 steps (mismatches)", bad, 0);
    bad = 0;
    for (int j = 0; j < 512; j++) if (recB[j] + recB[j + 512] != 4096) bad++;
    check("R6 half-turn antisymmetry (mismatches)", bad, 0);
  endtask

  task automatic testLoop();
    startRun(32'h0, 16'h1234, 16'h5679, 16'h0ABC);
    loopEn = 1'b1;
    @(negedge clk);
    check("R8 txLeft loopback", txLeft, 16'h1234);
    check("R8 txRight loopback", txRight, 16'h5679);
    loopEn = 1'b0;
    @(negedge clk);
    check("R8 txLeft microphone", txLeft, 16'h0ABC);
    check("R8 txRight silent", txRight, 0);
    loopEn = 1'b1;
  endtask

  initial begin
    testReset();
    testCardinal();
    testScale();
    testKeyOff();
    testHold();
    testSweep();
    testLoop();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule